// File: doc/BRIEF.md
# Stochastic Decision Counter and Termination Control

This block sits beside the node array of a stochastic iterative decoder. Every variable node delivers one output bit per decoding cycle, and the block keeps one signed, saturating up/down counter per node that integrates this bit stream. The sign of each counter is the node's current hard decision, which is available on every clock so that external parity logic can evaluate the check equations against it.

A controller counts decoding cycles for the current block. A block is opened with a start pulse, which clears every counter and latches a programmable cycle limit. Decoding ends at the first clock on which all parity checks report satisfied, once at least one cycle has run. It also ends when the cycle count reaches the limit. In either case a one-clock done pulse is raised, together with a flag that tells whether the checks converged.

The cycle counter is 16 bits wide, so limits of tens of thousands of cycles (10,000 or 60,000, for example) fit. The node logic and the parity-check logic are outside this block. The parity result arrives as a vector with one bit per check.

Top module: `stoch_decision_ctrl`

## Requirements
- R1: On each accepted decoding cycle, a node's counter goes up by one when its input bit is 1 and down by one when it is 0.
- R2: Counters are two's-complement values of CNT_W bits. They stay at 2^(CNT_W-1)-1 when incremented there and at -2^(CNT_W-1) when decremented there, and never wrap.
- R3: hard_dec[i] is the sign bit of counter i on every clock: 0 stands for a decoded +1 and 1 for a decoded -1.
- R4: A start pulse clears all counters and the cycle count to zero, latches max_cycles as the limit and sets busy. It takes priority over every other input in the same clock.
- R5: A decoding cycle is accepted only on a clock where busy is 1, cycle_en is 1, and no termination occurs. Each accepted cycle adds one to cycle_count. When idle, cycle_en and node_bits leave hard_dec and cycle_count unchanged.
- R6: While busy, on a clock where cycle_count is at least 1 and every parity_ok bit is 1 (1 = check satisfied), the next edge ends decoding: busy falls, done=1, converged=1, and no cycle is accepted in that clock.
- R7: While busy, on a clock where cycle_count equals the limit and the checks are not all satisfied, the next edge ends decoding with done=1 and converged=0. A limit of 0 ends the block with no cycle run. Limits up to 65535 are supported.
- R8: When the limit is reached on the same clock that all checks are satisfied, converged is 1.
- R9: done is high for exactly one clock per block, and converged is 1 only while done is 1.
- R10: After reset, busy, done and converged are 0, cycle_count is 0 and every hard_dec bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block: clear counters, latch limit |
| cycle_en | input | 1 | node_bits hold one decoding cycle's output |
| node_bits | input | N_NODES | One output bit per variable node |
| parity_ok | input | N_CHECKS | Per-check satisfied flag, evaluated on hard_dec |
| max_cycles | input | 16 | Decoding cycle limit, latched at start |
| hard_dec | output | N_NODES | Counter sign bits, 1 = decoded -1 |
| busy | output | 1 | A block is being decoded |
| done | output | 1 | One-clock end-of-block pulse |
| converged | output | 1 | With done: all checks were satisfied |
| cycle_count | output | 16 | Decoding cycles accepted in this block |

## Verification
Every result is registered, so the effect of a start, an accepted cycle or a termination shows one edge after the clock that carried the stimulus. Inputs are changed on the falling edge, and outputs are compared on the falling edge after the next rising edge. A termination condition presented in one clock therefore produces done in the following sample, and the sample after that shows the pulse gone. The bench keeps its own saturating model of each counter and compares hard_dec after every step. Across all runs, termination is checked at the exact cycle counts of 0, 1, 2, 3 and 60,000.

// File: rtl/stoch_dec_pkg.sv
package stoch_dec_pkg;

    localparam int CYC_W = 16;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             conv;
        logic [CYC_W-1:0] cyc;
        logic [CYC_W-1:0] lim;
    } ctrl_state_t;

endpackage

// File: rtl/sd_node_counter.sv
module sd_node_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic upd_i,
    input  logic bit_i,
    output logic sign_o
);
    localparam logic signed [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};

    logic signed [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (upd_i) begin
            if (bit_i) begin
                if (cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
            end else begin
                if (cnt_q != MINV) cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sign_o = cnt_q[CNT_W-1];

    // R2
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && bit_i && cnt_q == MAXV) |=> (cnt_q == MAXV));
    // R2
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clr_i && !bit_i && cnt_q == MINV) |=> (cnt_q == MINV));
    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/sd_cycle_ctrl.sv
module sd_cycle_ctrl
    import stoch_dec_pkg::*;
#(
    parameter int N_CHECKS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cycle_en_i,
    input  logic [N_CHECKS-1:0] parity_ok_i,
    input  logic [CYC_W-1:0]    max_cycles_i,
    output logic                clr_o,
    output logic                upd_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                conv_o,
    output logic [CYC_W-1:0]    cyc_o
);
    ctrl_state_t st_d, st_q;
    logic        all_ok;
    logic        ran_one;

    assign all_ok  = &parity_ok_i;
    assign ran_one = (st_q.cyc != '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.conv = 1'b0;
        upd_o     = 1'b0;
        clr_o     = start_i;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cyc  = '0;
            st_d.lim  = max_cycles_i;
        end else if (st_q.busy) begin
            if (ran_one && all_ok) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.conv = 1'b1;
            end else if (st_q.cyc >= st_q.lim) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else if (cycle_en_i) begin
                upd_o    = 1'b1;
                st_d.cyc = st_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign conv_o = st_q.conv;
    assign cyc_o  = st_q.cyc;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    conv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> done_o);
    // R7
    cyc_le_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cyc <= st_q.lim));
    // R6
    early_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && conv_o) |-> (cyc_o != '0));
    // R6
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(cyc_o));

endmodule

// File: rtl/stoch_decision_ctrl.sv
module stoch_decision_ctrl
    import stoch_dec_pkg::*;
#(
    parameter int N_NODES  = 8,
    parameter int N_CHECKS = 4,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cycle_en,
    input  logic [N_NODES-1:0]  node_bits,
    input  logic [N_CHECKS-1:0] parity_ok,
    input  logic [CYC_W-1:0]    max_cycles,
    output logic [N_NODES-1:0]  hard_dec,
    output logic                busy,
    output logic                done,
    output logic                converged,
    output logic [CYC_W-1:0]    cycle_count
);
    logic clr;
    logic upd;

    sd_cycle_ctrl #(
        .N_CHECKS(N_CHECKS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .cycle_en_i   (cycle_en),
        .parity_ok_i  (parity_ok),
        .max_cycles_i (max_cycles),
        .clr_o        (clr),
        .upd_o        (upd),
        .busy_o       (busy),
        .done_o       (done),
        .conv_o       (converged),
        .cyc_o        (cycle_count)
    );

    for (genvar i = 0; i < N_NODES; i++) begin : g_node
        sd_node_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .upd_i  (upd),
            .bit_i  (node_bits[i]),
            .sign_o (hard_dec[i])
        );
    end

    // R5
    no_update_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(hard_dec));

endmodule

// File: tb/stoch_decision_ctrl_test.sv
`timescale 1ns/1ps
module stoch_decision_ctrl_test;
    localparam int NN = 8;
    localparam int NC = 4;
    localparam int CW = 4;
    localparam int SMAX = (1 << (CW-1)) - 1;
    localparam int SMIN = -(1 << (CW-1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cycle_en = 1'b0;
    logic [NN-1:0] node_bits = '0;
    logic [NC-1:0] parity_ok = '0;
    logic [15:0]   max_cycles = '0;
    logic [NN-1:0] hard_dec;
    logic          busy, done, converged;
    logic [15:0]   cycle_count;

    int checks = 0;
    int errors = 0;
    int model [NN];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stoch_decision_ctrl #(.N_NODES(NN), .N_CHECKS(NC), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cycle_en(cycle_en),
        .node_bits(node_bits), .parity_ok(parity_ok), .max_cycles(max_cycles),
        .hard_dec(hard_dec), .busy(busy), .done(done), .converged(converged),
        .cycle_count(cycle_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NN-1:0] model_dec();
        logic [NN-1:0] r;
        for (int i = 0; i < NN; i++) r[i] = (model[i] < 0);
        return r;
    endfunction

    task automatic model_step(input logic [NN-1:0] b);
        for (int i = 0; i < NN; i++) begin
            if (b[i]) begin if (model[i] < SMAX) model[i]++; end
            else      begin if (model[i] > SMIN) model[i]--; end
        end
    endtask

    task automatic do_start(input logic [15:0] lim);
        start = 1'b1; max_cycles = lim; tick(); start = 1'b0;
        for (int i = 0; i < NN; i++) model[i] = 0;
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NN-1:0] b;
        logic [NN-1:0] held;
        bit early;
        int acc;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 converged", converged, 0);
        check("R10 cycle_count", cycle_count, 0);
        check("R10 hard_dec", hard_dec, 0);

        // R4 start
        do_start(16'd1000);
        check("R4 busy", busy, 1);
        check("R4 cycle_count", cycle_count, 0);
        check("R3 hard_dec zero=+1", hard_dec, 0);

        // R1 R2 R3 R5 sweep with gaps
        acc = 0;
        for (int dc = 0; dc < 56; dc++) begin
            b[0] = 1'b1;
            b[1] = 1'b0;
            b[2] = (dc < 20);
            b[3] = dc[0];
            b[4] = (dc % 3) != 0;
            b[5] = !(dc >= 10 && dc < 30);
            b[6] = dc[2];
            b[7] = (dc % 5) == 0;
            node_bits = b;
            cycle_en = (dc % 7) != 6;
            tick();
            if (cycle_en) begin model_step(b); acc++; end
            check("R1 R2 R3 hard_dec", hard_dec, model_dec());
        end
        cycle_en = 1'b0;
        check("R5 cycle_count", cycle_count, acc);
        check("R1 busy during sweep", busy, 1);

        // R4 start wins over a concurrent cycle_en
        node_bits = '1; cycle_en = 1'b1;
        do_start(16'd1000);
        cycle_en = 1'b0;
        check("R4 restart hard_dec", hard_dec, 0);
        check("R4 restart cycle_count", cycle_count, 0);

        // R6 early termination after one cycle
        parity_ok = '1;
        do_start(16'd1000);
        check("R6 no end with zero cycles", done, 0);
        node_bits = 8'hA5; cycle_en = 1'b1; tick(); cycle_en = 1'b0;
        model_step(8'hA5);
        check("R6 one cycle accepted", cycle_count, 1);
        check("R6 not yet done", done, 0);
        tick();
        check("R6 done", done, 1);
        check("R6 converged", converged, 1);
        check("R6 busy low", busy, 0);
        check("R6 count", cycle_count, 1);
        tick();
        check("R9 done pulse", done, 0);
        check("R9 converged cleared", converged, 0);
        held = hard_dec;
        check("R3 hard_dec after done", held, model_dec());
        // R5 idle input ignored
        node_bits = ~held; cycle_en = 1'b1; tick(); tick(); cycle_en = 1'b0;
        check("R5 idle hard_dec", hard_dec, held);
        check("R5 idle cycle_count", cycle_count, 1);

        // R7 partial parity, cap of 3
        parity_ok = 4'b1011;
        do_start(16'd3);
        cycle_en = 1'b1; node_bits = '1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R7 no early end", done, 0);
        end
        tick(); cycle_en = 1'b0;
        check("R7 done at cap", done, 1);
        check("R7 not converged", converged, 0);
        check("R7 count at cap", cycle_count, 3);

        // R8 cap and parity together
        parity_ok = '0;
        do_start(16'd2);
        cycle_en = 1'b1; tick(); tick(); cycle_en = 1'b0;
        parity_ok = '1;
        tick();
        check("R8 done", done, 1);
        check("R8 converged", converged, 1);
        check("R8 count", cycle_count, 2);

        // R7 limit zero
        parity_ok = '1;
        do_start(16'd0);
        tick();
        check("R7 zero limit done", done, 1);
        check("R7 zero limit converged", converged, 0);
        check("R7 zero limit count", cycle_count, 0);

        // R7 large cap
        parity_ok = '0;
        do_start(16'd60000);
        cycle_en = 1'b1;
        early = 1'b0;
        for (int k = 0; k < 60000; k++) begin
            tick();
            if (done) early = 1'b1;
        end
        check("R7 no done before 60000", early, 0);
        check("R7 count 60000", cycle_count, 60000);
        tick(); cycle_en = 1'b0;
        check("R7 done at 60000", done, 1);
        check("R7 converged 60000", converged, 0);
        check("R7 count held", cycle_count, 60000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule